// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block models the device side of a byte-wide parallel NOR flash. A host writes command bytes on the same bus it uses for data. The block decodes those bytes and switches between three read views: array contents, identifier bytes and a status byte. It also runs two-step sequences that program a single byte or erase a whole block of a small internal memory.

Program and erase each keep the device busy for a set number of clocks, given as parameters. While busy, the device ignores further writes and every read returns the status byte with its ready bit clear. The status byte flags program and erase failures separately. Those flags stay set until the host writes a clear command. Reads are registered: the byte selected at the clock edge where `rd_en` is high appears on `rdata` after that edge and holds until the next read.

Top module: `nor_flash_cmd`

## Requirements
- R1: After reset, array reads return 0xFF at every address, and the status byte reads 0x80.
- R2: Command 0x90 selects identifier view. A read whose two low address bits are 0 returns `MFR_ID`. When those bits equal `DEV_ID_OFS` (1 by default, 2 for the larger variant), the read returns `DEV_ID`. Any other offset returns 0x00, in any block.
- R3: Command 0xFF selects array view, and reads return stored bytes.
- R4: Command 0x40 followed by a data byte programs the byte at the data write's address. The stored value becomes old AND data, and no other byte changes.
- R5: A program that would turn any stored 0 bit into 1 sets status bit 4. The stored value is still old AND data.
- R6: Command 0x20 followed by 0xD0 at any address sets every byte of the block holding that address to 0xFF. The block is selected by the address bits above the low `BLK_AW` bits, and other blocks are left untouched.
- R7: Command 0x20 followed by any byte other than 0xD0 performs no erase and sets both status bit 5 and status bit 4.
- R8: Command 0x70 selects status view. The status byte has bit 7 = ready, bit 5 = erase error, bit 4 = program error, and all other bits 0.
- R9: Command 0x50 clears bits 5 and 4 and leaves the read view unchanged.
- R10: While an operation runs, every read returns the status byte with bit 7 = 0. A program stays busy for `PROG_CYCLES` clocks after its data write, and an erase stays busy for max(`ERASE_CYCLES`, block size) clocks after its confirm write.
- R11: Writes that arrive while busy have no effect.
- R12: Commands 0x40 and 0x20 switch reads to status view. That view remains after the operation ends, until another view command arrives.
- R13: An unrecognised command byte changes neither the read view nor the error bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Command or data byte |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; `rdata` updates after this edge |
| rdata | output | 8 | Byte selected by the current read view |

## Verification
The hardest states to reach are writes that land while an operation is in flight, and the exact cycle at which busy ends. A write's effect only becomes visible after the operation completes, so it is easy to miss. The bench starts a program and, while it runs, issues view-changing commands. It then shows that the status view survived once the operation ended. Status is polled one read per clock from the cycle after the data or confirm write, so the poll count pins the busy length to the exact clock.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM    = 8'h40;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;

    typedef enum logic [1:0] {
        VIEW_ARRAY  = 2'd0,
        VIEW_ID     = 2'd1,
        VIEW_STATUS = 2'd2
    } view_e;

    typedef enum logic [1:0] {
        SEQ_NONE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2
    } seq_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
    } err_t;

    function automatic logic [7:0] status_byte(input logic busy, input err_t e);
        logic [7:0] s;
        s               = 8'h00;
        s[ST_READY]     = ~busy;
        s[ST_ERASE_ERR] = e.erase_err;
        s[ST_PROG_ERR]  = e.prog_err;
        return s;
    endfunction

    function automatic logic sets_bits(input logic [7:0] old_b, input logic [7:0] new_b);
        return |(~old_b & new_b);
    endfunction

endpackage

// File: rtl/nfc_decode.sv
module nfc_decode
    import nfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       busy,
    input  logic [7:0] old_byte,
    output view_e      view_q,
    output seq_e       seq_q,
    output err_t       err_q,
    output logic       start_prog,
    output logic       start_erase
);

    logic accept;

    always_comb begin
        accept      = wr_en && !busy;
        start_prog  = accept && (seq_q == SEQ_PROG);
        start_erase = accept && (seq_q == SEQ_ERASE) && (wdata == CMD_CONFIRM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            view_q <= VIEW_ARRAY;
            seq_q  <= SEQ_NONE;
            err_q  <= '0;
        end else if (accept) begin
            unique case (seq_q)
                SEQ_PROG: begin
                    seq_q <= SEQ_NONE;
                    if (sets_bits(old_byte, wdata))
                        err_q.prog_err <= 1'b1;
                end
                SEQ_ERASE: begin
                    seq_q <= SEQ_NONE;
                    if (wdata != CMD_CONFIRM) begin
                        err_q.erase_err <= 1'b1;
                        err_q.prog_err  <= 1'b1;
                    end
                end
                default: begin
                    unique case (wdata)
                        CMD_READ_ARRAY: view_q <= VIEW_ARRAY;
                        CMD_READ_ID:    view_q <= VIEW_ID;
                        CMD_READ_STAT:  view_q <= VIEW_STATUS;
                        CMD_CLR_STAT:   err_q  <= '0;
                        CMD_PROGRAM: begin
                            seq_q  <= SEQ_PROG;
                            view_q <= VIEW_STATUS;
                        end
                        CMD_ERASE: begin
                            seq_q  <= SEQ_ERASE;
                            view_q <= VIEW_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/nfc_timer.sv
module nfc_timer #(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 96,
    parameter int BLK_AW       = 6,
    parameter int BLK_W        = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_prog,
    input  logic                    start_erase,
    input  logic [BLK_W-1:0]        erase_blk,
    output logic                    busy,
    output logic                    wipe_en,
    output logic [BLK_W+BLK_AW-1:0] wipe_addr
);

    localparam int BLK_BYTES = 1 << BLK_AW;
    localparam int ERASE_LEN = (ERASE_CYCLES > BLK_BYTES) ? ERASE_CYCLES : BLK_BYTES;
    localparam int MAX_LEN   = (ERASE_LEN > PROG_CYCLES) ? ERASE_LEN : PROG_CYCLES;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              wiping_q;
    logic [BLK_W-1:0]  blk_q;
    logic [BLK_AW-1:0] off_q;

    always_comb begin
        busy      = (cnt_q != '0);
        wipe_en   = wiping_q;
        wipe_addr = {blk_q, off_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            wiping_q <= 1'b0;
            blk_q    <= '0;
            off_q    <= '0;
        end else if (start_prog) begin
            cnt_q <= CNT_W'(PROG_CYCLES);
        end else if (start_erase) begin
            cnt_q    <= CNT_W'(ERASE_LEN);
            wiping_q <= 1'b1;
            blk_q    <= erase_blk;
            off_q    <= '0;
        end else begin
            if (busy)
                cnt_q <= cnt_q - CNT_W'(1);
            if (wiping_q) begin
                off_q <= off_q + BLK_AW'(1);
                if (&off_q)
                    wiping_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nfc_mem.sv
module nfc_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_comb rdata = cells[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
    import nfc_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         BLK_AW       = 6,
    parameter int         PROG_CYCLES  = 8,
    parameter int         ERASE_CYCLES = 96,
    parameter logic [7:0] MFR_ID       = 8'h5C,
    parameter logic [7:0] DEV_ID       = 8'h3E,
    parameter int         DEV_ID_OFS   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata
);

    localparam int BLK_W = ADDR_W - BLK_AW;

    view_e              view_q;
    seq_e               seq_q;
    err_t               err_q;
    logic               start_prog;
    logic               start_erase;
    logic               busy;
    logic               wipe_en;
    logic [ADDR_W-1:0]  wipe_addr;
    logic [7:0]         cell_rd;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_waddr;
    logic [7:0]         mem_wdata;
    logic [7:0]         id_byte;
    logic [7:0]         rd_val;

    nfc_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .busy        (busy),
        .old_byte    (cell_rd),
        .view_q      (view_q),
        .seq_q       (seq_q),
        .err_q       (err_q),
        .start_prog  (start_prog),
        .start_erase (start_erase)
    );

    nfc_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .BLK_AW       (BLK_AW),
        .BLK_W        (BLK_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .erase_blk   (addr[ADDR_W-1:BLK_AW]),
        .busy        (busy),
        .wipe_en     (wipe_en),
        .wipe_addr   (wipe_addr)
    );

    always_comb begin
        mem_we    = start_prog | wipe_en;
        mem_waddr = wipe_en ? wipe_addr : addr;
        mem_wdata = wipe_en ? 8'hFF : (cell_rd & wdata);
    end

    nfc_mem #(
        .AW (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr),
        .rdata (cell_rd)
    );

    always_comb begin
        if (addr[1:0] == 2'd0)
            id_byte = MFR_ID;
        else if (addr[1:0] == 2'(DEV_ID_OFS))
            id_byte = DEV_ID;
        else
            id_byte = 8'h00;
    end

    always_comb begin
        if (busy) begin
            rd_val = status_byte(busy, err_q);
        end else begin
            unique case (view_q)
                VIEW_ARRAY: rd_val = cell_rd;
                VIEW_ID:    rd_val = id_byte;
                default:    rd_val = status_byte(busy, err_q);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_val;
    end

endmodule

// File: rtl/nor_flash_cmd_chk.sv
module nor_flash_cmd_chk
    import nfc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       busy,
    input view_e      view_q,
    input seq_e       seq_q,
    input logic       err_prog,
    input logic       err_erase
);

    assert_busy_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rdata[ST_READY] == 1'b0));

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(err_prog) && $stable(err_erase)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && seq_q == SEQ_NONE && wdata == CMD_CLR_STAT)
        |=> (!err_prog && !err_erase));

    assert_bad_seq_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && seq_q == SEQ_ERASE && wdata != CMD_CONFIRM)
        |=> (err_prog && err_erase && !busy));

    assert_confirm_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && seq_q == SEQ_ERASE && wdata == CMD_CONFIRM) |=> busy);

    assert_status_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !busy && view_q == VIEW_STATUS) |=> rdata[ST_READY]);

endmodule

bind nor_flash_cmd nor_flash_cmd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .busy      (busy),
    .view_q    (view_q),
    .seq_q     (seq_q),
    .err_prog  (err_q.prog_err),
    .err_erase (err_q.erase_err)
);

// File: tb/nor_flash_cmd_tb.sv
module nor_flash_cmd_tb;

    localparam int PROG_CYC  = 8;
    localparam int ERASE_LEN = 96;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nor_flash_cmd u_dut (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic poll_ready(input logic [7:0] a, output int polls, output logic [7:0] st);
        polls = 0;
        st = 8'h00;
        for (int i = 0; i < 1000; i++) begin
            rd(a, st);
            polls++;
            if (st[7]) break;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(8'h00, d); check("R1", "array byte 0x00 after reset", d, 8'hFF);
        rd(8'hBF, d); check("R1", "array byte 0xBF after reset", d, 8'hFF);
        wr(8'h00, 8'h70);
        rd(8'h00, d); check("R8", "status after reset", d, 8'h80);
        wr(8'h00, 8'hFF);
    endtask

    task automatic t_ident;
        logic [7:0] d;
        wr(8'h00, 8'h90);
        rd(8'h00, d); check("R2", "manufacturer byte", d, 8'h5C);
        rd(8'h01, d); check("R2", "device byte", d, 8'h3E);
        rd(8'h02, d); check("R2", "unused id offset", d, 8'h00);
        rd(8'h41, d); check("R2", "device byte in block 1", d, 8'h3E);
        wr(8'h00, 8'hFF);
        rd(8'h01, d); check("R3", "array view after 0xFF", d, 8'hFF);
    endtask

    task automatic t_program;
        logic [7:0] d;
        int polls;
        wr(8'h00, 8'h40);
        wr(8'h13, 8'hA5);
        poll_ready(8'h13, polls, d);
        check_int("R10", "program busy length in polls", polls, PROG_CYC + 1);
        check("R12", "status view after program", d, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h13, d); check("R4", "programmed byte", d, 8'hA5);
        rd(8'h12, d); check("R4", "neighbour byte untouched", d, 8'hFF);
        wr(8'h00, 8'h40);
        wr(8'h13, 8'h81);
        poll_ready(8'h13, polls, d);
        check("R5", "clearing-only program has no error", d, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h13, d); check("R4", "stored old AND new", d, 8'h81);
    endtask

    task automatic t_prog_error;
        logic [7:0] d;
        int polls;
        wr(8'h00, 8'h40);
        wr(8'h13, 8'hFF);
        poll_ready(8'h13, polls, d);
        check("R5", "status after 0->1 attempt", d, 8'h90);
        wr(8'h00, 8'h50);
        rd(8'h00, d); check("R9", "status after clear, view kept", d, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h13, d); check("R5", "byte unchanged by 0->1 attempt", d, 8'h81);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] d;
        int polls;
        wr(8'h00, 8'h40);
        wr(8'h05, 8'h00);
        rd(8'h05, d); check("R10", "read during program gives busy status", d, 8'h00);
        wr(8'h00, 8'hFF);
        wr(8'h00, 8'h90);
        wr(8'h00, 8'h20);
        poll_ready(8'h00, polls, d);
        rd(8'h00, d); check("R11", "view still status after ignored writes", d, 8'h80);
        wr(8'h05, 8'hD0);
        rd(8'h05, d); check("R11", "ignored 0x20 left no pending erase", d, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h05, d); check("R4", "byte programmed to zero", d, 8'h00);
    endtask

    task automatic t_erase;
        logic [7:0] d;
        int polls;
        wr(8'h00, 8'h40);
        wr(8'h47, 8'h12);
        poll_ready(8'h47, polls, d);
        wr(8'h10, 8'h20);
        wr(8'h2A, 8'hD0);
        poll_ready(8'h2A, polls, d);
        check_int("R10", "erase busy length in polls", polls, ERASE_LEN + 1);
        check("R12", "status after erase", d, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h13, d); check("R6", "erased byte 0x13", d, 8'hFF);
        rd(8'h05, d); check("R6", "erased byte 0x05", d, 8'hFF);
        rd(8'h3F, d); check("R6", "erased last byte of block", d, 8'hFF);
        rd(8'h47, d); check("R6", "other block untouched", d, 8'h12);
    endtask

    task automatic t_bad_sequence;
        logic [7:0] d;
        wr(8'h40, 8'h20);
        wr(8'h47, 8'h33);
        rd(8'h47, d); check("R7", "status after bad erase sequence", d, 8'hB0);
        wr(8'h00, 8'hFF);
        rd(8'h47, d); check("R7", "no erase on bad sequence", d, 8'h12);
        wr(8'h00, 8'hA7);
        rd(8'h47, d); check("R13", "unknown command keeps array view", d, 8'h12);
        wr(8'h00, 8'h70);
        rd(8'h00, d); check("R13", "unknown command kept error bits", d, 8'hB0);
        wr(8'h00, 8'h50);
        rd(8'h00, d); check("R9", "errors cleared", d, 8'h80);
        wr(8'h00, 8'h90);
        wr(8'h00, 8'hA7);
        rd(8'h00, d); check("R13", "unknown command keeps id view", d, 8'h5C);
        wr(8'h00, 8'hFF);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ident();
        t_program();
        t_prog_error();
        t_busy_ignore();
        t_erase();
        t_bad_sequence();
        finish_run();
    end

endmodule